// File: doc/BRIEF.md
# Multi-Lane Tone Synthesizer with Sync Blanking

This block is a direct digital synthesizer for a converter whose sample clock runs a fixed multiple faster than the core clock. In each core cycle it produces `LANES` amplitude samples side by side. Lane k carries the tone `k` sample steps further on than lane 0, so the lanes read from lane 0 upward form one continuous waveform at the fast rate.

A data-sync input holds the tone at rest. While sync is active every lane outputs zero and the phase accumulators stand still. When sync is released, every lane accumulator is loaded with the programmed start phase plus its own lane offset. A short sync pulse is stretched inside the block to `LANES` cycles, so a release always re-phases all lanes together. A valid input travels with the samples and is forced low whenever the samples are blanked.

Phase is converted to amplitude by a per-lane piecewise-parabolic approximation of a sine. It has no stored table and feeds one output register.

Top module: `mdds_top`

## Requirements
- R1: During reset and after it, `samples_o` is all zero and `valid_o` is 0. Both stay that way until the first release of sync.
- R2: Sync is released at the clock edge where the stretched sync first reads low. On the next clock edge, lane k outputs A(init_phase + k*freq_word). Here A is the amplitude function of R7, and the phase arithmetic is modulo 2^16.
- R3: Each later cycle with sync low advances every lane by LANES*freq_word. The m-th cycle after the first sample shows A(init_phase + k*freq_word + m*LANES*freq_word) on lane k.
- R4: Suppose `sync_in` is high at a clock edge. Then all lanes of `samples_o` are zero after the second edge counted from it.
- R5: The release edge comes exactly LANES edges after the last edge at which `sync_in` is high, whether the pulse lasts one cycle or many. The outputs stay zero up to and including the release edge.
- R6: `valid_o` equals `valid_in` delayed by two clock edges. It is 0 whenever the samples of that cycle are blanked by sync or by a block that has not yet been phased.
- R7: Take p = the top 8 bits of a 16-bit lane phase, and x = p[6:0]. Then A = 7*x*(128-x) when p[7]=0, and A = -(7*x*(128-x)) when p[7]=1. A is a 16-bit two's-complement value. Lane k occupies bits [16k+15:16k] of `samples_o`.
- R8: Phase sums that pass 2^16 wrap around modulo 2^16.
- R9: Sync can be asserted again while the tone runs. The outputs then blank, and the next release re-phases all lanes from the current `init_phase` and `freq_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_word | input | 16 | Phase step per fast sample |
| init_phase | input | 16 | Phase of lane 0 at release |
| sync_in | input | 1 | Data sync; high holds the tone at zero |
| valid_in | input | 1 | Incoming valid qualifier |
| samples_o | output | LANES*16 | Packed lane amplitudes, lane 0 in the low bits |
| valid_o | output | 1 | Valid aligned with `samples_o` |

## Verification
The timing is counted from the last edge at which `sync_in` is sampled high. The release falls LANES edges later, and the outputs must still be zero after that edge. The first phased sample appears one edge after the release, and each following edge brings the next step. Blanking shows two edges after sync is sampled, and `valid_o` follows `valid_in` by two edges. Inputs change only on falling edges. Each check waits the stated number of rising edges and then samples at the next falling edge, so every comparison is made at its due cycle and no sooner.

// File: rtl/mdds_pkg.sv
package mdds_pkg;
    localparam int PHASE_W = 16;
    localparam int AMP_W   = 16;

    typedef struct packed {
        logic [7:0] stretch;
        logic       sync;
        logic       phased;
        logic       blank;
        logic       vld1;
        logic       vld2;
    } sync_state_t;
endpackage

// File: rtl/mdds_sync_ctrl.sv
module mdds_sync_ctrl #(
    parameter int LANES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic valid_in,
    output logic fall_o,
    output logic run_o,
    output logic blank_o,
    output logic valid_o
);
    import mdds_pkg::*;

    localparam logic [7:0] STRETCH_LOAD = 8'(LANES - 1);

    sync_state_t st_d, st_q;
    logic        sync_eff;
    logic        fall;

    always_comb begin
        st_d     = st_q;
        sync_eff = sync_in || (st_q.stretch != 8'd0);
        fall     = st_q.sync && !sync_eff;

        if (sync_in) begin
            st_d.stretch = STRETCH_LOAD;
        end else if (st_q.stretch != 8'd0) begin
            st_d.stretch = st_q.stretch - 8'd1;
        end

        st_d.sync   = sync_eff;
        st_d.phased = st_q.phased || fall;
        st_d.blank  = sync_eff || !(st_q.phased || fall);
        st_d.vld1   = valid_in && !st_d.blank;
        st_d.vld2   = st_q.vld1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stretch: 8'd0, sync: 1'b0, phased: 1'b0,
                      blank: 1'b1, vld1: 1'b0, vld2: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o  = fall;
    assign run_o   = !sync_eff && st_q.phased && !fall;
    assign blank_o = st_q.blank;
    assign valid_o = st_q.vld2;
endmodule

// File: rtl/mdds_phase.sv
module mdds_phase #(
    parameter int LANES = 4,
    parameter int PW    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fall_i,
    input  logic                    run_i,
    input  logic [PW-1:0]           freq_word,
    input  logic [PW-1:0]           init_phase,
    output logic [LANES-1:0][PW-1:0] phase_o
);
    localparam logic [PW-1:0] LANE_MUL = PW'(LANES);

    logic [PW-1:0] step;
    assign step = PW'(freq_word * LANE_MUL);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [PW-1:0] LANE_IDX = PW'(k);
        logic [PW-1:0] acc_d, acc_q;

        always_comb begin
            acc_d = acc_q;
            if (fall_i) begin
                acc_d = PW'(init_phase + freq_word * LANE_IDX);
            end else if (run_i) begin
                acc_d = acc_q + step;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else begin
                acc_q <= acc_d;
            end
        end

        assign phase_o[k] = acc_q;
    end
endmodule

// File: rtl/mdds_amp.sv
module mdds_amp #(
    parameter int PW = 16,
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic [PW-1:0]        phase_i,
    output logic signed [DW-1:0] amp_o
);
    localparam int HALF  = 2 ** (AW - 1);
    localparam int PEAK  = HALF * HALF / 4;
    localparam int SCALE = (2 ** (DW - 1) - 1) / PEAK;

    logic [AW-1:0]   idx;
    logic [AW-2:0]   x;
    logic [31:0]     mag;
    logic [31:0]     rest;

    always_comb begin
        idx  = phase_i[PW-1 -: AW];
        x    = idx[AW-2:0];
        rest = 32'(HALF) - 32'(x);
        mag  = 32'(x) * rest * 32'(SCALE);
        if (idx[AW-1]) begin
            amp_o = -DW'(mag);
        end else begin
            amp_o = DW'(mag);
        end
    end
endmodule

// File: rtl/mdds_top.sv
module mdds_top #(
    parameter int LANES = 4,
    parameter int PW    = 16,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PW-1:0]       freq_word,
    input  logic [PW-1:0]       init_phase,
    input  logic                sync_in,
    input  logic                valid_in,
    output logic [LANES*DW-1:0] samples_o,
    output logic                valid_o
);
    logic                     fall_w;
    logic                     run_w;
    logic                     blank_w;
    logic [LANES-1:0][PW-1:0] phase_w;
    logic [LANES*DW-1:0]      amp_w;
    logic [LANES*DW-1:0]      smp_d, smp_q;

    mdds_sync_ctrl #(.LANES(LANES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .valid_in (valid_in),
        .fall_o   (fall_w),
        .run_o    (run_w),
        .blank_o  (blank_w),
        .valid_o  (valid_o)
    );

    mdds_phase #(.LANES(LANES), .PW(PW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall_w),
        .run_i      (run_w),
        .freq_word  (freq_word),
        .init_phase (init_phase),
        .phase_o    (phase_w)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_amp
        logic signed [DW-1:0] a;
        mdds_amp #(.PW(PW), .AW(AW), .DW(DW)) u_amp (
            .phase_i (phase_w[k]),
            .amp_o   (a)
        );
        assign amp_w[k*DW +: DW] = a;
    end

    always_comb begin
        smp_d = blank_w ? '0 : amp_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign samples_o = smp_q;
endmodule

// File: rtl/mdds_chk.sv
module mdds_chk #(
    parameter int LANES = 4,
    parameter int PW    = 16,
    parameter int DW    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sync_in,
    input logic                valid_in,
    input logic [PW-1:0]       init_phase,
    input logic                fall_w,
    input logic [PW-1:0]       lane0_phase,
    input logic [LANES*DW-1:0] samples_o,
    input logic                valid_o
);
    logic [7:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 8'hFF;
        end else if (sync_in) begin
            since_q <= 8'd0;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_in, 2) |-> (samples_o == '0));

    p_release_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_w |-> (since_q == 8'(LANES - 1)));

    p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!$past(sync_in, 2) && $past(valid_in, 2)));

    p_init_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fall_w) |-> (lane0_phase == $past(init_phase)));
endmodule

bind mdds_top mdds_chk #(.LANES(LANES), .PW(PW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_in     (sync_in),
    .valid_in    (valid_in),
    .init_phase  (init_phase),
    .fall_w      (fall_w),
    .lane0_phase (phase_w[0]),
    .samples_o   (samples_o),
    .valid_o     (valid_o)
);

// File: tb/sim_mdds_top.sv
`timescale 1ns/1ps
module sim_mdds_top;
    localparam int LANES = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [15:0]         freq_word = '0;
    logic [15:0]         init_phase = '0;
    logic                sync_in = 1'b0;
    logic                valid_in = 1'b0;
    logic [LANES*16-1:0] samples_o;
    logic                valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mdds_top #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .init_phase(init_phase),
        .sync_in(sync_in), .valid_in(valid_in), .samples_o(samples_o), .valid_o(valid_o)
    );

    function automatic logic [15:0] amp_ref(input logic [15:0] ph);
        int x, y;
        x = int'(ph[14:8]);
        y = 7 * x * (128 - x);
        if (ph[15]) y = -y;
        return 16'(y);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_lanes(input string tag, input int m);
        for (int k = 0; k < LANES; k++) begin
            logic [15:0] ph;
            ph = 16'(init_phase + 16'(k) * freq_word + 16'(m * LANES) * freq_word);
            check(tag, 64'(samples_o[k*16 +: 16]), 64'(amp_ref(ph)));
        end
    endtask

    // Hold sync for nhigh edges, release, and stand on the negedge of the first sample (m = 0).
    task automatic sync_release(input int nhigh, input string tag);
        @(negedge clk) sync_in = 1'b1;
        repeat (nhigh) @(posedge clk);
        @(negedge clk) sync_in = 1'b0;
        repeat (LANES) @(posedge clk);
        @(negedge clk);
        check({tag, " R5 zero through release"}, 64'(samples_o), 64'd0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 reset samples", 64'(samples_o), 64'd0);
        check("R1 reset valid", 64'(valid_o), 64'd0);
        @(negedge clk) rst_n = 1'b1;
        valid_in = 1'b1;
        freq_word = 16'h0100;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check("R1 unphased samples", 64'(samples_o), 64'd0);
        check("R1 unphased valid", 64'(valid_o), 64'd0);
    endtask

    task automatic t_basic;
        init_phase = 16'h0000;
        freq_word  = 16'h0100;
        sync_release(3, "basic");
        check_lanes("R2 R7 first sample", 0);
        check("R6 valid with first sample", 64'(valid_o), 64'd1);
        for (int m = 1; m < 6; m++) begin
            @(posedge clk);
            @(negedge clk);
            check_lanes("R3 advance", m);
        end
    endtask

    task automatic t_short_pulse;
        init_phase = 16'h1234;
        freq_word  = 16'h0321;
        sync_release(1, "short");
        check_lanes("R5 R2 short pulse phases all lanes", 0);
        @(posedge clk);
        @(negedge clk);
        check_lanes("R3 after short pulse", 1);
    endtask

    task automatic t_wrap;
        init_phase = 16'hF000;
        freq_word  = 16'h7123;
        sync_release(2, "wrap");
        for (int m = 0; m < 5; m++) begin
            check_lanes("R8 wrap", m);
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic t_blank_valid;
        int m0;
        init_phase = 16'h4000;
        freq_word  = 16'h00A0;
        sync_release(2, "valid");
        m0 = 0;
        for (int i = 0; i < 6; i++) begin
            logic v;
            v = (i % 3) != 1;
            valid_in = v;
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check("R6 valid delay", 64'(valid_o), 64'(v));
        end
        valid_in = 1'b1;
        sync_in = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R4 blank while sync", 64'(samples_o), 64'd0);
        check("R6 valid low while sync", 64'(valid_o), 64'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 blank held", 64'(samples_o), 64'd0);
        sync_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_resync;
        init_phase = 16'h2000;
        freq_word  = 16'h0400;
        sync_release(1, "first");
        @(posedge clk);
        @(negedge clk);
        init_phase = 16'h9ABC;
        freq_word  = 16'h0155;
        sync_release(4, "resync");
        check_lanes("R9 resync new phase", 0);
        @(posedge clk);
        @(negedge clk);
        check_lanes("R9 resync advance", 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_basic();
        t_short_pulse();
        t_wrap();
        t_blank_valid();
        t_resync();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule